// File: doc/BRIEF.md
# Programmable Digital Input Glitch Filter

This block cleans up to 32 raw digital inputs, grouped as four 8-bit ports, before edge or interrupt logic sees them. Each raw input is first brought into the clock domain by a two-stage synchronizer. Every channel then runs a small two-state machine. The settled state `CH_IDLE` means the output matches the synchronized input. The qualifying state `CH_COUNT` means a different level has been seen and is being timed. A shared 20-bit interval, counted in ticks of a fixed time base, sets how long a new level must hold before the output takes it.

Transitions of the channel machine:
- `CH_IDLE -> CH_COUNT` when the input differs from the output while filtering is active.
- `CH_COUNT -> CH_IDLE` with the output updated when the tick count reaches the interval.
- `CH_COUNT -> CH_IDLE` without an update when the input returns to the output level.
- `CH_COUNT -> CH_IDLE` with an immediate update when the channel leaves filtering (enable cleared or interval set to zero).

Outside filtering, `CH_IDLE` copies the input straight to the output. A divider produces one tick every `TICK_DIV` system clocks; with the default of 20 and a 100 MHz clock, that is one tick every 200 ns. Software reaches the interval and the per-port enable masks through a byte-wide register port with a combinational read.

Top module: `dglitch_filter`

## Requirements
- R1: After reset the interval is 0, every enable mask is 0x00 and `dout` is all zeros.
- R2: Register map. The interval occupies bytes 0x08 (bits 7:0), 0x09 (bits 15:8) and 0x0A (bits 19:16). Bits 7:4 written to 0x0A are dropped and read back as 0. The enable mask of port p is at 0x44 + p*0x10, and its bit b controls channel p*8+b. Every mapped byte reads back the value stored there.
- R3: A write to an unmapped address changes no register, and a read of an unmapped address returns 0x00.
- R4: A channel whose enable bit is 0 shows a new raw level on `dout` at the third rising clock edge after the change, and not before.
- R5: An enabled channel with interval N>0 holds its old level on `dout` through edge (N-1)*TICK_DIV+3 after a held raw change. It shows the new level by edge N*TICK_DIV+3.
- R6: A raw pulse shorter than the interval never reaches `dout`. The pulse restarts the channel's stability count, so a later held change again takes the full interval.
- R7: An enabled channel with interval 0 behaves exactly like a bypassed channel (R4 timing).
- R8: Changing an enable bit never glitches `dout`. Clearing it while a change is being qualified updates the output at the edge after the register write. Setting it while input and output agree leaves the output unchanged.
- R9: Enable bits act per channel: filtering one channel leaves the bypass timing of all other channels untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| din | input | 32 | Raw asynchronous channel inputs |
| dout | output | 32 | Filtered channel outputs |

## Verification
A channel machine stuck in `CH_COUNT`, or a counter that survives a return to the settled level, shows up on `dout`. The channel switches earlier than edge (N-1)*TICK_DIV+3 after a held change, or it never switches. Either error is visible within one interval of the stimulus. A broken decode or byte lane shows at `reg_rdata` on the very next read. A mask bit steering the wrong channel shows as one `dout` bit arriving late or early by up to a full interval, while its neighbours keep the three-edge bypass timing.

// File: rtl/dglitch_pkg.sv
package dglitch_pkg;
    localparam int PORT_W = 8;
    localparam logic [7:0] IVAL_BASE   = 8'h08;
    localparam logic [7:0] MASK_BASE   = 8'h44;
    localparam logic [7:0] MASK_STRIDE = 8'h10;

    typedef enum logic {
        CH_IDLE  = 1'b0,
        CH_COUNT = 1'b1
    } ch_state_e;
endpackage

// File: rtl/dgf_tick.sv
module dgf_tick #(
    parameter int DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || cnt_q == LAST) cnt_q <= '0;
        else                         cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    if (DIV > 1) begin : g_gap_chk
        AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick); // R5
    end
endmodule

// File: rtl/dgf_regs.sv
module dgf_regs
    import dglitch_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int IVAL_W    = 20
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic [7:0]                  reg_addr,
    input  logic [7:0]                  reg_wdata,
    output logic [7:0]                  reg_rdata,
    output logic [IVAL_W-1:0]           ival,
    output logic [NUM_PORTS*PORT_W-1:0] en
);
    localparam int IVAL_BYTES = (IVAL_W + 7) / 8;

    logic [IVAL_W-1:0]        ival_q, ival_d;
    logic [PORT_W-1:0]        mask_q [NUM_PORTS];
    logic [IVAL_BYTES*8-1:0]  ival_wide;

    always_comb begin
        ival_wide = '0;
        ival_wide[IVAL_W-1:0] = ival_q;
        for (int b = 0; b < IVAL_BYTES; b++) begin
            if (reg_wr && reg_addr == 8'(IVAL_BASE + b))
                ival_wide[b*8 +: 8] = reg_wdata;
        end
        ival_d = ival_wide[IVAL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ival_q <= '0;
            for (int p = 0; p < NUM_PORTS; p++) mask_q[p] <= '0;
        end else begin
            ival_q <= ival_d;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (reg_wr && reg_addr == 8'(MASK_BASE + p * MASK_STRIDE))
                    mask_q[p] <= reg_wdata;
            end
        end
    end

    always_comb begin
        logic [IVAL_BYTES*8-1:0] rd_wide;
        rd_wide = '0;
        rd_wide[IVAL_W-1:0] = ival_q;
        reg_rdata = 8'h00;
        for (int b = 0; b < IVAL_BYTES; b++) begin
            if (reg_addr == 8'(IVAL_BASE + b)) reg_rdata = rd_wide[b*8 +: 8];
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (reg_addr == 8'(MASK_BASE + p * MASK_STRIDE)) reg_rdata = mask_q[p];
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_en
        assign en[p*PORT_W +: PORT_W] = mask_q[p];
    end

    assign ival = ival_q;

    AST_IVAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(ival_q)); // R3
    AST_MASK0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(mask_q[0])); // R3
endmodule

// File: rtl/dgf_chan.sv
module dgf_chan
    import dglitch_pkg::*;
#(
    parameter int IVAL_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din_raw,
    input  logic              tick,
    input  logic              en,
    input  logic [IVAL_W-1:0] ival,
    output logic              dout
);
    logic              s1_q, s2_q;
    logic              out_q, out_d;
    ch_state_e         st_q, st_d;
    logic [IVAL_W-1:0] cnt_q, cnt_d;
    logic [IVAL_W:0]   cnt_inc;
    logic              pass;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= din_raw;
            s2_q <= s1_q;
        end
    end

    assign pass    = !en || (ival == '0);
    assign cnt_inc = {1'b0, cnt_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= CH_IDLE;
            cnt_q <= '0;
            out_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            out_q <= out_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        out_d = out_q;
        unique case (st_q)
            CH_IDLE: begin
                if (s2_q != out_q) begin
                    if (pass) begin
                        out_d = s2_q;
                    end else begin
                        st_d  = CH_COUNT;
                        cnt_d = '0;
                    end
                end
            end
            CH_COUNT: begin
                if (s2_q == out_q) begin
                    st_d  = CH_IDLE;
                    cnt_d = '0;
                end else if (pass) begin
                    out_d = s2_q;
                    st_d  = CH_IDLE;
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_inc >= {1'b0, ival}) begin
                        out_d = s2_q;
                        st_d  = CH_IDLE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_inc[IVAL_W-1:0];
                    end
                end
            end
            default: st_d = CH_IDLE;
        endcase
    end

    assign dout = out_q;

    AST_OUT_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_q) |-> out_q == $past(s2_q)); // R4
    AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> out_q == $past(s2_q)); // R4
    AST_FILT_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ival != '0 && !tick) |=> $stable(out_q)); // R5
    AST_ZERO_IVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ival == '0) |=> out_q == $past(s2_q)); // R7
endmodule

// File: rtl/dglitch_filter.sv
module dglitch_filter
    import dglitch_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int IVAL_W    = 20,
    parameter int TICK_DIV  = 20
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic [7:0]                  reg_addr,
    input  logic [7:0]                  reg_wdata,
    output logic [7:0]                  reg_rdata,
    input  logic [NUM_PORTS*PORT_W-1:0] din,
    output logic [NUM_PORTS*PORT_W-1:0] dout
);
    localparam int NUM_CH = NUM_PORTS * PORT_W;

    logic              tick;
    logic [IVAL_W-1:0] ival;
    logic [NUM_CH-1:0] en;

    dgf_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    dgf_regs #(.NUM_PORTS(NUM_PORTS), .IVAL_W(IVAL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .ival     (ival),
        .en       (en)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dgf_chan #(.IVAL_W(IVAL_W)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .din_raw(din[c]),
            .tick   (tick),
            .en     (en[c]),
            .ival   (ival),
            .dout   (dout[c])
        );
    end
endmodule

// File: tb/test_dglitch_filter.sv
module test_dglitch_filter;
    localparam int DIV = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [31:0] din = 32'h0;
    logic [31:0] dout;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    dglitch_filter #(.NUM_PORTS(4), .IVAL_W(20), .TICK_DIV(DIV)) i_dglitch_filter (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .din(din), .dout(dout)
    );

    // {req[3:0], wr_addr, wdata, rd_addr, expected}
    localparam logic [35:0] VEC [12] = '{
        {4'd2, 8'h08, 8'h12, 8'h08, 8'h12},
        {4'd2, 8'h09, 8'h34, 8'h09, 8'h34},
        {4'd2, 8'h0A, 8'hFF, 8'h0A, 8'h0F},
        {4'd2, 8'h44, 8'hA5, 8'h44, 8'hA5},
        {4'd2, 8'h54, 8'h3C, 8'h54, 8'h3C},
        {4'd2, 8'h64, 8'h01, 8'h64, 8'h01},
        {4'd2, 8'h74, 8'h80, 8'h74, 8'h80},
        {4'd3, 8'h45, 8'h77, 8'h44, 8'hA5},
        {4'd3, 8'h0B, 8'h99, 8'h0A, 8'h0F},
        {4'd3, 8'h84, 8'h55, 8'h74, 8'h80},
        {4'd3, 8'h40, 8'hEE, 8'h08, 8'h12},
        {4'd3, 8'h46, 8'h00, 8'h45, 8'h00}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_ival(input logic [19:0] v);
        wr(8'h08, v[7:0]);
        wr(8'h09, v[15:8]);
        wr(8'h0A, {4'h0, v[19:16]});
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic check_reset_state;
        logic [7:0] v;
        foreach (VEC[i]) begin
            if (VEC[i][35:32] == 4'd2) begin
                rd(VEC[i][31:24], v);
                chk(v == 8'h00, "R1 register cleared", {24'h0, v}, 32'h0);
            end
        end
        chk(dout == 32'h0, "R1 dout cleared", dout, 32'h0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v;
        logic [31:0] old_v, new_v, exp_v;
        step(1);
        do_reset();
        check_reset_state();

        // Register map walk (R2 mapped bytes, R3 unmapped writes/reads)
        for (int i = 0; i < 12; i++) begin
            wr(VEC[i][31:24], VEC[i][23:16]);
            rd(VEC[i][15:8], v);
            chk(v == VEC[i][7:0], (VEC[i][35:32] == 4'd2) ? "R2 map" : "R3 unmapped",
                {24'h0, v}, {24'h0, VEC[i][7:0]});
        end

        set_ival(20'h0);
        wr(8'h44, 8'h00); wr(8'h54, 8'h00); wr(8'h64, 8'h00); wr(8'h74, 8'h00);

        // R4: bypass, synchronizer latency
        din = 32'hA5A5_0F0F;
        step(2);
        chk(dout == 32'h0, "R4 bypass before 3rd edge", dout, 32'h0);
        step(1);
        chk(dout == 32'hA5A5_0F0F, "R4 bypass at 3rd edge", dout, 32'hA5A5_0F0F);
        din = 32'h5A5A_F0F0;
        step(2);
        chk(dout == 32'hA5A5_0F0F, "R4 bypass hold", dout, 32'hA5A5_0F0F);
        step(1);
        chk(dout == 32'h5A5A_F0F0, "R4 bypass update", dout, 32'h5A5A_F0F0);

        // R5: filtered channel, interval 3 ticks
        set_ival(20'd3);
        wr(8'h44, 8'hFF);
        step(2);
        din[7:0] = 8'h0F;
        step(2 * DIV + 3);
        chk(dout[7:0] == 8'hF0, "R5 held before interval", {24'h0, dout[7:0]}, 32'hF0);
        step(DIV);
        chk(dout[7:0] == 8'h0F, "R5 updated after interval", {24'h0, dout[7:0]}, 32'h0F);

        // R6: short pulse rejected, count restarts
        din[7:0] = 8'hF0;
        step(30);
        chk(dout[7:0] == 8'h0F, "R6 pulse not passed", {24'h0, dout[7:0]}, 32'h0F);
        din[7:0] = 8'h0F;
        step(5);
        chk(dout[7:0] == 8'h0F, "R6 pulse gone", {24'h0, dout[7:0]}, 32'h0F);
        din[7:0] = 8'hF0;
        step(2 * DIV + 3);
        chk(dout[7:0] == 8'h0F, "R6 count restarted", {24'h0, dout[7:0]}, 32'h0F);
        step(DIV);
        chk(dout[7:0] == 8'hF0, "R6 held change passes", {24'h0, dout[7:0]}, 32'hF0);

        // R7: enabled with interval zero equals bypass
        set_ival(20'd0);
        step(2);
        din[7:0] = 8'h3C;
        step(2);
        chk(dout[7:0] == 8'hF0, "R7 zero interval before 3rd edge", {24'h0, dout[7:0]}, 32'hF0);
        step(1);
        chk(dout[7:0] == 8'h3C, "R7 zero interval at 3rd edge", {24'h0, dout[7:0]}, 32'h3C);

        // R8: enable changes are glitch free
        set_ival(20'd3);
        step(2);
        din[7:0] = 8'hC3;
        step(10);
        chk(dout[7:0] == 8'h3C, "R8 qualifying", {24'h0, dout[7:0]}, 32'h3C);
        wr(8'h44, 8'h00);
        chk(dout[7:0] == 8'h3C, "R8 no change at write edge", {24'h0, dout[7:0]}, 32'h3C);
        step(1);
        chk(dout[7:0] == 8'hC3, "R8 disable releases", {24'h0, dout[7:0]}, 32'hC3);
        wr(8'h44, 8'hFF);
        step(5);
        chk(dout[7:0] == 8'hC3, "R8 enable keeps level", {24'h0, dout[7:0]}, 32'hC3);

        // R9: only channel 8 filtered
        wr(8'h44, 8'h00);
        wr(8'h54, 8'h01);
        step(2);
        old_v = dout;
        new_v = ~din;
        din   = new_v;
        step(3);
        exp_v = (new_v & ~32'h100) | (old_v & 32'h100);
        chk(dout == exp_v, "R9 only channel 8 delayed", dout, exp_v);
        step(3 * DIV + 3);
        chk(dout == new_v, "R9 channel 8 catches up", dout, new_v);

        // R1: reset mid-run
        do_reset();
        din = 32'h0;
        step(3);
        check_reset_state();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule